// File: doc/BRIEF.md
# Chroma Input Reformatter (4:1:1 / 4:2:2 to 9-bit 4:2:2)

This block takes one video line at a time from an input bus and hands it on as a 9-bit 4:2:2 pixel stream. Three input layouts are accepted, selected by a format input:
- parallel 4:2:2, with luma and chroma on separate buses;
- double-rate UYVY, with every word on the luma bus;
- 4:1:1, where the chroma bus carries one U and one V word per group of four pixels.

For 4:1:1 input, the chroma samples that 4:2:2 needs but the input lacks are interpolated with a four-tap kernel, [-1, 9, 9, -1]/16. The samples that the input does carry pass through unchanged. The write enable can act as a qualifier, marking the word in the same cycle, or as a prequalifier, marking the word in the following cycle. A line-start pulse restarts the pixel count.

Each line of `LINE_LEN` pixels is collected in one half of a ping-pong buffer. Once the line is complete, it is emitted at one pixel per clock while the other half fills. This keeps the interpolator simple at both line edges: a tap that would fall outside the line takes the nearest sample of the line instead. Several optional conversions apply to the data as it is written into the buffer:
- U and V can be exchanged;
- the chroma MSB can be inverted, to convert signed chroma to the internal offset-binary form;
- the LSB can be cleared, for 8-bit sources wired to the upper bits of the 9-bit bus.

Embedded synchronisation words are not decoded. Words outside enabled cycles are simply not taken.

Top module: `chroma_reformat`

## Requirements
- R1: Output pixel p of a line (p counted from 0) carries luma on y_o and one chroma sample on c_o. uslot_o is 1 on even p (the U slot) and 0 on odd p (the V slot).
- R2: A line holds LINE_LEN pixels. Pixel p appears with valid_o high in the (p+1)-th cycle after the clock edge that accepts the last input word of the line. valid_o is high for exactly those LINE_LEN cycles.
- R3: When preq_i=0, a word is taken in a cycle where we_i=1. When preq_i=1, a word is taken in the cycle after a cycle where we_i=1.
- R4: fmt_i=0 selects parallel 4:2:2. Each taken word is one pixel: luma from y_i, chroma from c_i. The chroma word is U on even pixels and V on odd pixels.
- R5: fmt_i=1 selects UYVY. Words are taken from y_i only, in the repeating order U, Y(even pixel), V, Y(odd pixel), and c_i is ignored.
- R6: fmt_i=2 selects 4:1:1. The c_i word of pixel 4k is U[k] and the c_i word of pixel 4k+1 is V[k]; c_i on pixels 4k+2 and 4k+3 is ignored. Output chroma on pixels 4k and 4k+1 equals U[k] and V[k] unchanged.
- R7: In 4:1:1, output chroma on pixels 4k+2 and 4k+3 is (9*(s[k]+s[k+1]) - s[k-1] - s[k+2] + 8) >> 4 of its component, clamped to 0..511.
- R8: An interpolation tap index below 0 uses group 0. An index above LINE_LEN/4-1 uses the last group of the line.
- R9: swap_i=1 exchanges U and V: the U slot carries the V data and the V slot carries the U data, in every format.
- R10: cinv_i=1 inverts bit 8 of every input chroma word before any further processing.
- R11: narrow_i=1 forces bit 0 of every input luma and chroma word to 0 before any further processing.
- R12: A sol_i pulse makes the word taken in that cycle, or the next word taken, pixel 0. Words taken after pixel LINE_LEN-1 and before the next sol_i are ignored.
- R13: During and after reset, valid_o, uslot_o, y_o and c_o are 0 until the first line is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Input layout: 0 parallel 4:2:2, 1 UYVY, 2 4:1:1 |
| preq_i | input | 1 | 1: we_i leads the data by one cycle |
| swap_i | input | 1 | Exchange U and V |
| cinv_i | input | 1 | Invert chroma MSB on input |
| narrow_i | input | 1 | Clear input LSB (8-bit source) |
| sol_i | input | 1 | Line start pulse |
| we_i | input | 1 | Write enable (qualifier or prequalifier) |
| y_i | input | 9 | Luma bus, or all words in UYVY |
| c_i | input | 9 | Chroma bus |
| valid_o | output | 1 | Output pixel valid |
| uslot_o | output | 1 | 1 when c_o is the U slot |
| y_o | output | 9 | Output luma |
| c_o | output | 9 | Output chroma |

## Verification
Every output pixel is due at a cycle that is fixed once the last word of its line has been taken. Pixel p of a line must appear p+1 cycles after that edge. The driver notes the cycle counter at the falling edge just after the last in-line word is taken. It then queues each expected pixel with its exact due cycle, and the monitor compares the cycle stamp as well as the luma, chroma and slot values. An output that arrives late, arrives early, or is never queued fails. Gaps in the enable, prequalified timing, leading words before a restart and trailing words past the line end all move only the capture edge, and the stamps are computed from that edge.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    FMT_422P = 2'd0,
    FMT_UYVY = 2'd1,
    FMT_411  = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;
endpackage

// File: rtl/rfm_accept.sv
module rfm_accept import rfm_pkg::*; #(
  parameter  int DW       = 9,
  parameter  int LINE_LEN = 16,
  localparam int PW       = $clog2(LINE_LEN),
  localparam int CW       = $clog2(LINE_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic          preq_i,
  input  logic          cinv_i,
  input  logic          narrow_i,
  input  logic          sol_i,
  input  logic          we_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  output logic          wr_o,
  output logic [PW-1:0] widx_o,
  output logic [DW-1:0] wy_o,
  output logic [DW-1:0] wc_o,
  output logic          done_o
);
  logic          we_q, acc, uyvy, room;
  logic [CW-1:0] cnt, base_cnt;
  logic [1:0]    ph, base_ph;
  logic [DW-1:0] c_hold, y_n, c_n, u_n;

  always_comb begin
    acc      = preq_i ? we_q : we_i;
    uyvy     = (fmt_i == FMT_UYVY);
    y_n      = {y_i[DW-1:1], y_i[0] & ~narrow_i};
    c_n      = {c_i[DW-1] ^ cinv_i, c_i[DW-2:1], c_i[0] & ~narrow_i};
    u_n      = {y_i[DW-1] ^ cinv_i, y_i[DW-2:1], y_i[0] & ~narrow_i};
    base_cnt = sol_i ? '0 : cnt;
    base_ph  = sol_i ? '0 : ph;
    room     = base_cnt < CW'(LINE_LEN);
    // UYVY commits a pixel on each luma word (odd word phase)
    wr_o     = acc && room && (!uyvy || base_ph[0]);
    widx_o   = base_cnt[PW-1:0];
    wy_o     = y_n;
    wc_o     = uyvy ? c_hold : c_n;
    done_o   = wr_o && (base_cnt == CW'(LINE_LEN - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      cnt    <= '0;
      ph     <= '0;
      c_hold <= '0;
    end else begin
      we_q <= we_i;
      cnt  <= base_cnt + CW'(wr_o);
      ph   <= base_ph + 2'(acc);
      if (acc && uyvy && !base_ph[0]) c_hold <= u_n;
    end
  end
endmodule

// File: rtl/rfm_linebuf.sv
module rfm_linebuf #(
  parameter  int DW       = 9,
  parameter  int LINE_LEN = 16,
  localparam int PW       = $clog2(LINE_LEN)
) (
  input  logic                 clk_i,
  input  logic                 wr_i,
  input  logic                 wbank_i,
  input  logic [PW-1:0]        widx_i,
  input  logic [DW-1:0]        wy_i,
  input  logic [DW-1:0]        wc_i,
  input  logic                 rbank_i,
  input  logic [PW-1:0]        ridx_i,
  input  logic [3:0][PW-1:0]   cidx_i,
  output logic [DW-1:0]        ry_o,
  output logic [3:0][DW-1:0]   rc_o
);
  logic [1:0][DW-1:0]      by;
  logic [1:0][3:0][DW-1:0] bc;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] ym [LINE_LEN];
    logic [DW-1:0] cm [LINE_LEN];
    always_ff @(posedge clk_i) begin
      if (wr_i && (wbank_i == 1'(b))) begin
        ym[widx_i] <= wy_i;
        cm[widx_i] <= wc_i;
      end
    end
    assign by[b] = ym[ridx_i];
    for (genvar t = 0; t < 4; t++) begin : g_tap
      assign bc[b][t] = cm[cidx_i[t]];
    end
  end

  assign ry_o = by[rbank_i];
  assign rc_o = bc[rbank_i];
endmodule

// File: rtl/rfm_interp.sv
module rfm_interp #(
  parameter  int DW = 9,
  localparam int SW = DW + 6
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);
  logic signed [SW-1:0] sum, sh;

  always_comb begin
    sum = 9 * ($signed(SW'(b_i)) + $signed(SW'(c_i)))
          - $signed(SW'(a_i)) - $signed(SW'(d_i)) + 8;
    sh  = sum >>> 4;
    if (sum < 0)       q_o = '0;
    else if (sh > MAXV) q_o = '1;
    else               q_o = sh[DW-1:0];
  end
endmodule

// File: rtl/chroma_reformat.sv
module chroma_reformat import rfm_pkg::*; #(
  parameter int DW       = 9,
  parameter int LINE_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic          preq_i,
  input  logic          swap_i,
  input  logic          cinv_i,
  input  logic          narrow_i,
  input  logic          sol_i,
  input  logic          we_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  output logic          valid_o,
  output logic          uslot_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o
);
  localparam int PW = $clog2(LINE_LEN);
  localparam int GR = LINE_LEN / 4;
  localparam int KW = PW - 2;

  logic                wr, done, wbank, rbank, busy, comp, is411;
  logic [PW-1:0]       widx, rcnt;
  logic [DW-1:0]       wy, wc, ry, ip, c_nxt;
  logic [3:0][PW-1:0]  cidx;
  logic [3:0][DW-1:0]  rc;

  rfm_accept #(.DW(DW), .LINE_LEN(LINE_LEN)) u_acc (
    .clk_i, .rst_ni, .fmt_i, .preq_i, .cinv_i, .narrow_i, .sol_i, .we_i,
    .y_i, .c_i, .wr_o(wr), .widx_o(widx), .wy_o(wy), .wc_o(wc), .done_o(done)
  );

  rfm_linebuf #(.DW(DW), .LINE_LEN(LINE_LEN)) u_buf (
    .clk_i, .wr_i(wr), .wbank_i(wbank), .widx_i(widx), .wy_i(wy), .wc_i(wc),
    .rbank_i(rbank), .ridx_i(rcnt), .cidx_i(cidx), .ry_o(ry), .rc_o(rc)
  );

  rfm_interp #(.DW(DW)) u_ip (
    .a_i(rc[0]), .b_i(rc[1]), .c_i(rc[2]), .d_i(rc[3]), .q_o(ip)
  );

  always_comb begin : p_taps
    int km;
    is411 = (fmt_i == FMT_411);
    comp  = rcnt[0] ^ swap_i;
    for (int t = 0; t < 4; t++) begin
      km = int'(rcnt[PW-1:2]) + t - 1;
      if (km < 0)      km = 0;
      if (km > GR - 1) km = GR - 1;
      cidx[t] = {km[KW-1:0], 1'b0, comp};
    end
    if (!is411) cidx[1] = {rcnt[PW-1:1], comp};
    c_nxt = (is411 && rcnt[1]) ? ip : rc[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbank   <= 1'b0;
      rbank   <= 1'b0;
      busy    <= 1'b0;
      rcnt    <= '0;
      valid_o <= 1'b0;
      uslot_o <= 1'b0;
      y_o     <= '0;
      c_o     <= '0;
    end else begin
      if (done) begin
        rbank <= wbank;
        wbank <= ~wbank;
        busy  <= 1'b1;
        rcnt  <= '0;
      end else if (busy) begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == PW'(LINE_LEN - 1)) busy <= 1'b0;
      end
      valid_o <= busy;
      if (busy) begin
        y_o     <= ry;
        c_o     <= c_nxt;
        uslot_o <= ~rcnt[0];
      end
    end
  end
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter  int DW       = 9,
  parameter  int LINE_LEN = 16,
  localparam int CW       = $clog2(LINE_LEN + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          narrow_i,
  input logic          valid_o,
  input logic          uslot_o,
  input logic [DW-1:0] y_o
);
  logic [CW-1:0] vcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vcnt <= '0;
    else if (valid_o) vcnt <= (vcnt == CW'(LINE_LEN - 1)) ? '0 : vcnt + 1'b1;
    else              vcnt <= '0;
  end

  p_first_u_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> uslot_o);

  p_slot_alt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (uslot_o != $past(uslot_o)));

  p_burst_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> (vcnt == '0));

  p_line_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && vcnt == '0) |-> uslot_o);

  p_narrow_lsb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && narrow_i) |-> (y_o[0] == 1'b0));
endmodule

bind chroma_reformat rfm_checker #(.DW(DW), .LINE_LEN(LINE_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .narrow_i(narrow_i),
  .valid_o(valid_o), .uslot_o(uslot_o), .y_o(y_o)
);

// File: tb/sim_chroma_reformat.sv
module sim_chroma_reformat;
  localparam int LL = 16;
  localparam int GR = LL / 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = '0;
  logic       preq = 0, swap = 0, cinv = 0, narrow = 0, sol = 0, we = 0;
  logic [8:0] y_in = '0, c_in = '0;
  logic       valid, uslot;
  logic [8:0] y_out, c_out;

  always #5 clk = ~clk;

  chroma_reformat #(.DW(9), .LINE_LEN(LL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .preq_i(preq), .swap_i(swap),
    .cinv_i(cinv), .narrow_i(narrow), .sol_i(sol), .we_i(we),
    .y_i(y_in), .c_i(c_in), .valid_o(valid), .uslot_o(uslot),
    .y_o(y_out), .c_o(c_out)
  );

  typedef struct {int t; logic [8:0] y; logic [8:0] c; logic u; string tag;} exp_t;
  exp_t sb[$];
  exp_t m_e;
  int cyc = 0, n_run = 0, n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (sb.size() == 0) chk("R2 stray valid", 1, 0);
        else begin
          m_e = sb.pop_front();
          chk("R2 due cycle", cyc, m_e.t);
          chk({m_e.tag, " luma"}, int'(y_out), int'(m_e.y));
          chk({m_e.tag, " chroma"}, int'(c_out), int'(m_e.c));
          chk("R1 slot", int'(uslot), int'(m_e.u));
        end
      end else if (sb.size() != 0 && sb[0].t < cyc) begin
        chk("R2 missing pixel", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  function automatic int clampg(int k);
    if (k < 0) return 0;
    if (k > GR - 1) return GR - 1;
    return k;
  endfunction

  function automatic int interp(int a, int b, int c, int d);
    int s;
    s = 9 * (b + c) - a - d + 8;
    if (s < 0) return 0;
    s = s >> 4;
    return (s > 511) ? 511 : s;
  endfunction

  task automatic run_line(string tag, int f, bit pre, bit sw, bit inv, bit nar,
                          int kind, bit gaps, int prefix, int extra);
    logic [8:0] yv[LL], cv[LL], yn[LL], cn[LL];
    logic [8:0] wy[$], wc[$];
    bit         ws[$];
    int         cw[$];
    exp_t       ex[LL];
    int         last, n;
    for (int p = 0; p < LL; p++) begin
      yv[p] = 9'($urandom);
      cv[p] = 9'($urandom);
    end
    if (kind == 1) begin
      for (int k = 0; k < GR; k++) begin
        cv[4*k]   = (k % 4 == 1 || k % 4 == 2) ? 9'd511 : 9'd0;
        cv[4*k+1] = (k % 4 == 1 || k % 4 == 2) ? 9'd0 : 9'd511;
      end
    end
    for (int p = 0; p < LL; p++) begin
      yn[p] = nar ? (yv[p] & 9'h1FE) : yv[p];
      cn[p] = (nar ? (cv[p] & 9'h1FE) : cv[p]) ^ (inv ? 9'h100 : 9'h000);
    end
    for (int p = 0; p < LL; p++) begin
      int comp, k;
      comp = (p & 1) ^ int'(sw);
      k    = p >> 2;
      ex[p].y = yn[p];
      ex[p].u = ((p & 1) == 0);
      ex[p].tag = tag;
      if (f == 2) begin
        if ((p & 2) == 0) ex[p].c = cn[4*k + comp];
        else ex[p].c = 9'(interp(int'(cn[4*clampg(k-1)+comp]), int'(cn[4*clampg(k)+comp]),
                                 int'(cn[4*clampg(k+1)+comp]), int'(cn[4*clampg(k+2)+comp])));
      end else ex[p].c = cn[(p & ~1) | comp];
    end
    for (int i = 0; i < prefix; i++) begin
      wy.push_back(9'($urandom)); wc.push_back(9'($urandom)); ws.push_back(i == 0);
    end
    if (f == 1) begin
      for (int q = 0; q < LL / 2; q++) begin
        wy.push_back(cv[2*q]);   wc.push_back(9'($urandom)); ws.push_back(q == 0);
        wy.push_back(yv[2*q]);   wc.push_back(9'($urandom)); ws.push_back(0);
        wy.push_back(cv[2*q+1]); wc.push_back(9'($urandom)); ws.push_back(0);
        wy.push_back(yv[2*q+1]); wc.push_back(9'($urandom)); ws.push_back(0);
      end
    end else begin
      for (int p = 0; p < LL; p++) begin
        wy.push_back(yv[p]); wc.push_back(cv[p]); ws.push_back(p == 0);
      end
    end
    last = wy.size() - 1;
    for (int i = 0; i < extra; i++) begin
      wy.push_back(9'($urandom)); wc.push_back(9'($urandom)); ws.push_back(0);
    end
    if (pre) cw.push_back(-1);
    n = 0;
    for (int w = 0; w < wy.size(); w++) begin
      if (gaps && (n % 3 == 2)) begin cw.push_back(-1); n++; end
      cw.push_back(w); n++;
    end
    cw.push_back(-1);
    @(negedge clk);
    fmt = 2'(f); preq = pre; swap = sw; cinv = inv; narrow = nar;
    for (int c = 0; c < cw.size(); c++) begin
      @(negedge clk);
      if (c > 0 && cw[c-1] == last)
        for (int p = 0; p < LL; p++) begin
          ex[p].t = cyc + 1 + p;
          sb.push_back(ex[p]);
        end
      we = pre ? (c + 1 < cw.size() && cw[c+1] >= 0) : (cw[c] >= 0);
      if (cw[c] >= 0) begin
        y_in = wy[cw[c]]; c_in = wc[cw[c]]; sol = ws[cw[c]];
      end else begin
        y_in = 9'($urandom); c_in = 9'($urandom); sol = 1'b0;
      end
    end
    @(negedge clk);
    we = 0; sol = 0;
    repeat (LL + 6) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset valid", int'(valid), 0);
    chk("R13 reset luma", int'(y_out), 0);
    chk("R13 reset chroma", int'(c_out), 0);
    chk("R13 reset slot", int'(uslot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle after reset", int'(valid), 0);
    //            tag                    fmt pre sw inv nar kind gaps pfx ext
    run_line("R4 parallel",              0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_line("R3 prequal parallel",      0, 1, 0, 0, 0, 0, 1, 0, 0);
    run_line("R5 uyvy",                  1, 0, 0, 0, 0, 0, 1, 0, 0);
    run_line("R3 R5 uyvy prequal",       1, 1, 0, 0, 0, 0, 0, 0, 0);
    run_line("R6 R7 R8 411",             2, 0, 0, 0, 0, 0, 0, 0, 0);
    run_line("R3 R6 R8 411 prequal",     2, 1, 0, 0, 0, 0, 1, 0, 0);
    run_line("R7 R8 411 saturation",     2, 0, 0, 0, 0, 1, 0, 0, 0);
    run_line("R9 swap parallel",         0, 0, 1, 0, 0, 0, 0, 0, 0);
    run_line("R9 swap 411",              2, 0, 1, 0, 0, 0, 1, 0, 0);
    run_line("R9 swap uyvy",             1, 0, 1, 0, 0, 0, 0, 0, 0);
    run_line("R10 msb invert parallel",  0, 0, 0, 1, 0, 0, 0, 0, 0);
    run_line("R10 msb invert 411",       2, 0, 0, 1, 0, 1, 0, 0, 0);
    run_line("R10 msb invert uyvy",      1, 1, 0, 1, 0, 0, 1, 0, 0);
    run_line("R11 narrow parallel",      0, 0, 0, 0, 1, 0, 0, 0, 0);
    run_line("R11 narrow uyvy",          1, 0, 0, 0, 1, 0, 0, 0, 0);
    run_line("R11 narrow 411",           2, 1, 0, 0, 1, 0, 0, 0, 0);
    run_line("R12 restart and overrun",  0, 0, 0, 0, 0, 0, 1, 5, 3);
    run_line("R12 restart 411",          2, 1, 0, 0, 0, 0, 0, 3, 4);
    run_line("R12 restart uyvy",         1, 0, 0, 0, 0, 0, 0, 2, 5);
    chk("R2 scoreboard drained", sb.size(), 0);
    chk("R2 idle after last line", int'(valid), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule